// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a small word-addressed memory and arbitrates atomic read-modify-write sequences for several requesting contexts. A context is named by a CPU number together with a thread number. A load carrying the conditional flag places a reservation on the aligned line that holds its address. A later store carrying the conditional flag from the same context completes only if that reservation is still in the table. Any store that lands on a reserved line removes every reservation on that line, regardless of which context owns it. This applies to plain stores, successful conditional stores and failed conditional stores alike.

The table keeps one slot for each context, so a context never holds more than one reservation. All slots are compared against the incoming line in parallel in the same cycle. A response follows every request one clock later. It carries the read word for loads and a pass flag for stores. The memory write is gated by that same decision.

Top module: `llsc_monitor`

## Requirements
- R1: After the active-low synchronous reset, no reservation is held, `rsp_valid` and `rsp_ok` are 0, and a conditional store issued right after reset fails.
- R2: Every request accepted in cycle t produces `rsp_valid`=1 in cycle t+1, and `rsp_valid`=0 otherwise. For a load, `rsp_rdata` is the memory word at index (addr>>2) mod MEM_WORDS, including all earlier writes.
- R3: A plain store (write=1, cond=0) always writes memory and answers `rsp_ok`=1 with `rsp_rdata`=0.
- R4: A load with cond=1 sets its context's reservation to line addr>>4. A second such load from the same context replaces the line, and the old line is no longer reserved for it.
- R5: A conditional store (write=1, cond=1) succeeds only when its own context holds a reservation on the same line. On success, `rsp_ok`=1 and memory is written. Otherwise `rsp_ok`=0 and memory is unchanged.
- R6: Reservation matching ignores the low GRAN_BITS (default 4) address bits, so any two addresses inside one 16-byte line match.
- R7: Every store removes all reservations on its line, across all contexts. This includes plain stores, successful conditional stores and failed conditional stores.
- R8: A plain load (write=0, cond=0) neither creates nor changes any reservation.
- R9: The context index is cpu*N_THR+thr. Contexts that share a thread number but differ in CPU are distinct.
- R10: Responses to loads always carry `rsp_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_cond | input | 1 | Conditional flag: linked load or conditional store |
| req_cpu | input | CPU_W | CPU number of the requester |
| req_thr | input | THR_W | Thread number of the requester |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_rdata | output | DATA_W | Load data, zero for stores |
| rsp_ok | output | 1 | Store outcome: 1 = written |

## Verification
The hardest situation to reach is a failed conditional store that still has to remove another context's reservation on its line. A second hard case is several contexts sharing one line when a third context stores to a different offset in that line. The directed phase builds these cases by placing linked loads from two or three contexts on the same line. It then stores from a context whose own reservation points elsewhere and probes each former holder with its own conditional store. A random phase then confines addresses to a few lines, so that collisions, replacements and cross-context clears happen often.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_LINK  = 2'd1,
        OP_STORE = 2'd2,
        OP_COND  = 2'd3
    } llsc_op_e;

    function automatic llsc_op_e decode_op(input logic is_write, input logic is_cond);
        llsc_op_e op;
        if (is_write) op = is_cond ? OP_COND : OP_STORE;
        else          op = is_cond ? OP_LINK : OP_LOAD;
        return op;
    endfunction

endpackage

// File: rtl/llsc_resv_table.sv
module llsc_resv_table
    import llsc_pkg::*;
#(
    parameter int NCTX   = 4,
    parameter int LINE_W = 12,
    localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_valid,
    input  llsc_op_e                 op,
    input  logic [CTX_W-1:0]         ctx,
    input  logic [LINE_W-1:0]        line,
    output logic                     own_hit,
    output logic [NCTX-1:0]          slot_vld,
    output logic [NCTX*LINE_W-1:0]   slot_line
);

    typedef struct packed {
        logic [NCTX-1:0]              vld;
        logic [NCTX-1:0][LINE_W-1:0]  line;
    } tbl_t;

    tbl_t            tbl_d, tbl_q;
    logic [NCTX-1:0] match;

    always_comb begin
        tbl_d   = tbl_q;
        own_hit = 1'b0;
        for (int i = 0; i < NCTX; i++) begin
            match[i] = tbl_q.vld[i] && (tbl_q.line[i] == line);
            if (i == int'(ctx)) own_hit = match[i];
        end
        if (op_valid) begin
            unique case (op)
                OP_LINK: begin
                    for (int i = 0; i < NCTX; i++) begin
                        if (i == int'(ctx)) begin
                            tbl_d.vld[i]  = 1'b1;
                            tbl_d.line[i] = line;
                        end
                    end
                end
                OP_STORE, OP_COND: begin
                    for (int i = 0; i < NCTX; i++) begin
                        if (match[i]) tbl_d.vld[i] = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign slot_vld  = tbl_q.vld;
    assign slot_line = tbl_q.line;

endmodule

// File: rtl/llsc_word_store.sv
module llsc_word_store #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 64,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [WORDS];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = '0;
        if (rd_en) rdata_d = mem_q[idx];
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[idx] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int N_CPU     = 2,
    parameter int N_THR     = 2,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 64,
    parameter int GRAN_BITS = 4,
    localparam int CPU_W    = (N_CPU > 1) ? $clog2(N_CPU) : 1,
    localparam int THR_W    = (N_THR > 1) ? $clog2(N_THR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_cond,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [THR_W-1:0]  req_thr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_ok
);

    localparam int NCTX     = N_CPU * N_THR;
    localparam int CTX_W    = (NCTX > 1) ? $clog2(NCTX) : 1;
    localparam int LINE_W   = ADDR_W - GRAN_BITS;
    localparam int WORD_LSB = $clog2(DATA_W / 8);
    localparam int IDX_W    = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;

    typedef struct packed {
        logic vld;
        logic ok;
    } rsp_t;

    rsp_t                     rsp_d, rsp_q;
    llsc_op_e                 op;
    logic [CTX_W-1:0]         ctx;
    logic [LINE_W-1:0]        line;
    logic [IDX_W-1:0]         idx;
    logic                     own_hit;
    logic                     wr_en;
    logic                     rd_en;
    logic [NCTX-1:0]          resv_vld;
    logic [NCTX*LINE_W-1:0]   resv_line;
    logic                     unused_addr;

    always_comb begin
        op    = decode_op(req_write, req_cond);
        ctx   = CTX_W'(int'(req_cpu) * N_THR + int'(req_thr));
        line  = req_addr[ADDR_W-1:GRAN_BITS];
        idx   = req_addr[WORD_LSB +: IDX_W];
        rd_en = req_valid && !req_write;
        wr_en = req_valid && ((op == OP_STORE) || ((op == OP_COND) && own_hit));
        rsp_d.vld = req_valid;
        rsp_d.ok  = wr_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign unused_addr = ^req_addr;

    llsc_resv_table #(
        .NCTX   (NCTX),
        .LINE_W (LINE_W)
    ) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (req_valid),
        .op        (op),
        .ctx       (ctx),
        .line      (line),
        .own_hit   (own_hit),
        .slot_vld  (resv_vld),
        .slot_line (resv_line)
    );

    llsc_word_store #(
        .DATA_W (DATA_W),
        .WORDS  (MEM_WORDS)
    ) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .idx   (idx),
        .wdata (req_wdata),
        .rdata (rsp_rdata)
    );

    assign rsp_valid = rsp_q.vld;
    assign rsp_ok    = rsp_q.ok;

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int N_CPU     = 2,
    parameter int N_THR     = 2,
    parameter int ADDR_W    = 16,
    parameter int GRAN_BITS = 4,
    localparam int CPU_W    = (N_CPU > 1) ? $clog2(N_CPU) : 1,
    localparam int THR_W    = (N_THR > 1) ? $clog2(N_THR) : 1,
    localparam int NCTX     = N_CPU * N_THR,
    localparam int LINE_W   = ADDR_W - GRAN_BITS
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_write,
    input logic                   req_cond,
    input logic [CPU_W-1:0]       req_cpu,
    input logic [THR_W-1:0]       req_thr,
    input logic [ADDR_W-1:0]      req_addr,
    input logic                   rsp_valid,
    input logic                   rsp_ok,
    input logic [NCTX-1:0]        slot_vld,
    input logic [NCTX*LINE_W-1:0] slot_line
);

    int                cur_ctx;
    logic [LINE_W-1:0] cur_line;
    logic              own_vld;
    logic              st_seen_q, link_seen_q;
    logic [LINE_W-1:0] st_line_q, link_line_q;
    int                link_ctx_q;
    logic              st_line_held, link_slot_ok;

    always_comb begin
        cur_ctx  = int'(req_cpu) * N_THR + int'(req_thr);
        cur_line = req_addr[ADDR_W-1:GRAN_BITS];
        own_vld  = 1'b0;
        st_line_held = 1'b0;
        link_slot_ok = 1'b0;
        for (int i = 0; i < NCTX; i++) begin
            if (i == cur_ctx) own_vld = slot_vld[i];
            if (slot_vld[i] && slot_line[i*LINE_W +: LINE_W] == st_line_q) st_line_held = 1'b1;
            if (i == link_ctx_q && slot_vld[i] && slot_line[i*LINE_W +: LINE_W] == link_line_q)
                link_slot_ok = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_seen_q   <= 1'b0;
            link_seen_q <= 1'b0;
            st_line_q   <= '0;
            link_line_q <= '0;
            link_ctx_q  <= 0;
        end else begin
            st_seen_q   <= req_valid && req_write;
            link_seen_q <= req_valid && !req_write && req_cond;
            st_line_q   <= cur_line;
            link_line_q <= cur_line;
            link_ctx_q  <= cur_ctx;
        end
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_PLAIN_STORE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_cond) |=> rsp_ok); // R3
    AST_LOAD_NOT_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> !rsp_ok); // R10
    AST_SC_NEEDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_cond && !own_vld) |=> !rsp_ok); // R5
    AST_STORE_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        st_seen_q |-> !st_line_held); // R7
    AST_LINK_SETS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        link_seen_q |-> link_slot_ok); // R4

endmodule

bind llsc_monitor llsc_monitor_chk #(
    .N_CPU     (N_CPU),
    .N_THR     (N_THR),
    .ADDR_W    (ADDR_W),
    .GRAN_BITS (GRAN_BITS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_cond  (req_cond),
    .req_cpu   (req_cpu),
    .req_thr   (req_thr),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .slot_vld  (resv_vld),
    .slot_line (resv_line)
);

// File: tb/llsc_monitor_tb_top.sv
`timescale 1ns/1ps
module llsc_monitor_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_cond = 1'b0;
    logic [0:0]  req_cpu = '0;
    logic [0:0]  req_thr = '0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_ok;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference state
    logic [31:0] mem_m [64];
    bit          rv_m [4];
    int          rl_m [4];

    always #5 clk = ~clk;

    llsc_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cond(req_cond), .req_cpu(req_cpu), .req_thr(req_thr), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // assumes entry at a negedge; returns at the next negedge after checking the response
    task automatic do_req(input string tag, input bit w, input bit c, input int cpu,
                          input int thr, input int addr, input logic [31:0] data);
        int ctx, line, idx;
        bit own, ok;
        logic [31:0] exp_rd;
        ctx  = cpu * 2 + thr;
        line = addr >> 4;
        idx  = (addr >> 2) & 63;
        req_valid = 1'b1; req_write = w; req_cond = c;
        req_cpu = 1'(cpu); req_thr = 1'(thr); req_addr = 16'(addr); req_wdata = data;
        exp_rd = 32'h0;
        ok = 1'b0;
        if (!w) begin
            exp_rd = mem_m[idx];
            if (c) begin rv_m[ctx] = 1'b1; rl_m[ctx] = line; end
        end else begin
            own = rv_m[ctx] && rl_m[ctx] == line;
            ok  = !c || own;
            if (ok) mem_m[idx] = data;
            for (int i = 0; i < 4; i++) if (rv_m[i] && rl_m[i] == line) rv_m[i] = 1'b0;
        end
        @(negedge clk);
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " ok"}, 32'(rsp_ok), 32'(ok));
        chk({tag, " rdata"}, rsp_rdata, exp_rd);
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk("R2 idle valid", 32'(rsp_valid), 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin rv_m[i] = 1'b0; rl_m[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset valid", 32'(rsp_valid), 32'd0);
        chk("R1 reset ok", 32'(rsp_ok), 32'd0);
        // R1: conditional store right after reset fails (memory contents still unknown)
        req_valid = 1'b1; req_write = 1'b1; req_cond = 1'b1; req_cpu = 0; req_thr = 0;
        req_addr = 16'h0010; req_wdata = 32'hDEAD_0001;
        @(negedge clk);
        chk("R1 sc after reset", 32'(rsp_ok), 32'd0);
        idle(1);

        // R3: fill memory with plain stores
        for (int i = 0; i < 64; i++) do_req("R3 fill", 1, 0, i % 2, (i / 2) % 2, i * 4, 32'h1000_0000 + 32'(i * 7));
        // R2: read back a few
        do_req("R2 load", 0, 0, 0, 0, 16'h0010, 0);
        do_req("R10 load", 0, 0, 1, 1, 16'h00FC, 0);
        do_req("R2 load", 0, 0, 1, 0, 16'h0013, 0);

        // R6: link then conditional store at another offset in the same line
        do_req("R4 link", 0, 1, 0, 0, 16'h0020, 0);
        do_req("R6 sc same line", 1, 1, 0, 0, 16'h0028, 32'hAAAA_0006);
        do_req("R5 readback", 0, 0, 0, 0, 16'h0028, 0);
        do_req("R7 sc reuse", 1, 1, 0, 0, 16'h0020, 32'hBBBB_0007);
        do_req("R5 unchanged", 0, 0, 0, 0, 16'h0020, 0);

        // R7: three contexts on one line, plain store from a fourth clears all
        do_req("R4 link", 0, 1, 0, 0, 16'h0040, 0);
        do_req("R4 link", 0, 1, 0, 1, 16'h0044, 0);
        do_req("R4 link", 0, 1, 1, 1, 16'h004C, 0);
        do_req("R7 plain clr", 1, 0, 1, 0, 16'h0048, 32'hCCCC_0007);
        do_req("R7 sc ctx0", 1, 1, 0, 0, 16'h0040, 32'h1);
        do_req("R7 sc ctx1", 1, 1, 0, 1, 16'h0040, 32'h2);
        do_req("R7 sc ctx3", 1, 1, 1, 1, 16'h0040, 32'h3);

        // R4: replacement of a context's reservation
        do_req("R4 link", 0, 1, 0, 1, 16'h0060, 0);
        do_req("R4 relink", 0, 1, 0, 1, 16'h0080, 0);
        do_req("R4 sc old", 1, 1, 0, 1, 16'h0060, 32'h4);
        do_req("R4 sc new", 1, 1, 0, 1, 16'h0080, 32'h5);

        // R7: failed conditional store clears another context
        do_req("R4 link", 0, 1, 0, 0, 16'h00C0, 0);
        do_req("R4 link", 0, 1, 0, 1, 16'h00D0, 0);
        do_req("R7 failed sc", 1, 1, 0, 1, 16'h00C4, 32'h6);
        do_req("R7 victim sc", 1, 1, 0, 0, 16'h00C0, 32'h7);
        do_req("R5 own sc", 1, 1, 0, 1, 16'h00D0, 32'h8);

        // R8: plain loads do not reserve and do not disturb
        do_req("R8 plain load", 0, 0, 1, 0, 16'h00E0, 0);
        do_req("R8 sc no resv", 1, 1, 1, 0, 16'h00E0, 32'h9);
        do_req("R4 link", 0, 1, 1, 0, 16'h00E0, 0);
        do_req("R8 load other", 0, 0, 1, 0, 16'h0010, 0);
        do_req("R8 load same", 0, 0, 1, 0, 16'h00E4, 0);
        do_req("R8 sc kept", 1, 1, 1, 0, 16'h00E8, 32'hA);

        // R9: same thread number on different CPUs are separate contexts
        do_req("R4 link", 0, 1, 0, 1, 16'h0030, 0);
        do_req("R9 other cpu sc", 1, 1, 1, 1, 16'h0030, 32'hB);
        do_req("R9 own sc", 1, 1, 0, 1, 16'h0030, 32'hC);
        idle(2);

        // mixed random traffic on a few lines
        for (int n = 0; n < 3000; n++) begin
            int r, w, c, a;
            r = int'($urandom_range(0, 9));
            w = (r >= 5) ? 1 : 0;
            c = (r % 2 == 0) ? 1 : 0;
            a = int'($urandom_range(0, 255)) & 16'h0033;
            do_req("R5 random", w[0], c[0], int'($urandom_range(0, 1)), int'($urandom_range(0, 1)), a, $urandom);
            if (n % 97 == 0) idle(1);
        end
        idle(2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule